// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block brings a flat-panel display up and down in a fixed safe order. It drives three enables: one for the panel logic supply, one for the video link, and one for the backlight inverter. The link enable also gates the pixel and sync lines that go out to the panel. A single level request from the system says whether the panel should be on. All delays are counted in pulses of a one-millisecond tick, so the block can run on any system clock.

On power-up the logic supply comes on first. After `T_LINK` ticks the video link becomes valid. After another `T_LAMP` ticks the backlight lights. Power-down runs in the reverse order. The backlight goes dark first, and the link is held valid for `T_DIM` more ticks before it is dropped. The supply is then cut `T_DROP` ticks later. Once the supply is off, it stays off for at least `T_REST` ticks before a new power-up may start.

A request that drops part-way through power-up does not cut the sequence short. The current step finishes its delay, and then the normal power-down order runs from that point. Requests that arrive during power-down are held until the rest time has passed. The pixel path is a plain pass-through with no handshake. The panel samples it on every pixel clock, so there is no back-pressure.

Top module: `panel_pwr_seq`

## Requirements
- R1: During and directly after reset, `logic_en`, `link_en`, `lamp_en` and `seq_busy` are low and `pix_out` is all zero. Reset also starts a rest period of `T_REST` ticks.
- R2: On power-up, `logic_en` rises first. `link_en` rises once `T_LINK` ticks (1 to 50) have been seen with the supply on. `lamp_en` rises once `T_LAMP` more ticks have been seen with the link valid.
- R3: `lamp_en` is high only while `link_en` and `logic_en` are high, and it rises only after `link_en` was already high on the previous cycle.
- R4: On power-down, `lamp_en` falls first. `link_en` falls once `T_DIM` ticks (default 150) have been seen with the backlight off. `logic_en` falls once `T_DROP` more ticks have been seen.
- R5: `logic_en` rises only after at least `T_REST` ticks (default 200) have been seen with it low. A request made earlier leaves all enables low and is acted on when the count is reached.
- R6: `pix_out` equals `pix_in` while `link_en` is high and is all zero while it is low.
- R7: `link_en` is never high while `logic_en` is low.
- R8: If the request drops before power-up completes, the current step still runs its full delay. After the supply step, `logic_en` falls `T_DROP` ticks later and `link_en` never rises. After the link step, the link stays up for `T_DIM` ticks with the backlight off and then powers down.
- R9: `seq_busy` is high in every state other than fully off and fully lit.
- R10: A request that returns during power-down has no effect on it. The full power-down order and the rest time still run, and only then does a new power-up begin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse once per millisecond |
| panel_req | input | 1 | High while the panel should be on |
| pix_in | input | PIX_W | Colour bits plus sync and data-enable from the video source |
| logic_en | output | 1 | Panel logic supply enable |
| link_en | output | 1 | Video link valid; also gates `pix_out` |
| lamp_en | output | 1 | Backlight inverter enable |
| seq_busy | output | 1 | Sequencing in progress |
| pix_out | output | PIX_W | Gated pixel bus toward the panel |

## Verification
The request is tried in five patterns, each compared with a behavioural model on every cycle:

- **Early request after reset.** This shows whether the rest time gates the first power-up.
- **Full up, hold, then down.** This separates correct step delays from off-by-one tick counts.
- **Request dropped right after the supply comes on.** This exposes a sequencer that jumps straight to off or raises the link anyway.
- **Request dropped while the link is up but the backlight is still dark.** This checks that the dim wait still runs.
- **Request brought back during power-down.** This reveals a sequencer that re-lights without the full down order and rest time.

A changing pixel pattern runs throughout, so gating errors show in every phase.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  typedef enum logic [2:0] {
    PS_OFF    = 3'd0,
    PS_SUPPLY = 3'd1,
    PS_LINK   = 3'd2,
    PS_LIT    = 3'd3,
    PS_DIM    = 3'd4,
    PS_DROP   = 3'd5
  } pseq_state_t;

  function automatic int dmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pseq_timer.sv
module pseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)               count <= '0;
    else if (restart)         count <= '0;
    else if (tick && count != CMAX) count <= count + 1'b1;
  end
endmodule

// File: rtl/pseq_fsm.sv
module pseq_fsm
  import pseq_pkg::*;
#(
  parameter int T_LINK = 20,
  parameter int T_LAMP = 1,
  parameter int T_DIM  = 150,
  parameter int T_DROP = 5,
  parameter int T_REST = 200,
  parameter int CW     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        req,
  output pseq_state_t state
);
  pseq_state_t   state_nx;
  logic [CW-1:0] count;
  logic [CW-1:0] limit;
  logic          expired;
  logic          restart;

  always_comb begin
    case (state)
      PS_OFF:    limit = CW'(T_REST);
      PS_SUPPLY: limit = CW'(T_LINK);
      PS_LINK:   limit = CW'(T_LAMP);
      PS_DIM:    limit = CW'(T_DIM);
      PS_DROP:   limit = CW'(T_DROP);
      default:   limit = '0;
    endcase
  end

  assign expired = (count >= limit);

  always_comb begin
    state_nx = state;
    case (state)
      PS_OFF:    if (req && expired) state_nx = PS_SUPPLY;
      PS_SUPPLY: if (expired) state_nx = req ? PS_LINK : PS_DROP;
      PS_LINK:   if (expired) state_nx = req ? PS_LIT : PS_DIM;
      PS_LIT:    if (!req) state_nx = PS_DIM;
      PS_DIM:    if (expired) state_nx = PS_DROP;
      PS_DROP:   if (expired) state_nx = PS_OFF;
      default:   state_nx = PS_OFF;
    endcase
  end

  assign restart = (state_nx != state);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= PS_OFF;
    else        state <= state_nx;
  end

  pseq_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(restart),
    .tick   (tick),
    .count  (count)
  );
endmodule

// File: rtl/pseq_decode.sv
module pseq_decode
  import pseq_pkg::*;
(
  input  pseq_state_t state,
  output logic        logic_en,
  output logic        link_en,
  output logic        lamp_en,
  output logic        busy
);
  always_comb begin
    logic_en = 1'b0;
    link_en  = 1'b0;
    lamp_en  = 1'b0;
    busy     = 1'b1;
    case (state)
      PS_OFF:    busy = 1'b0;
      PS_SUPPLY: logic_en = 1'b1;
      PS_LINK:   begin logic_en = 1'b1; link_en = 1'b1; end
      PS_LIT:    begin logic_en = 1'b1; link_en = 1'b1; lamp_en = 1'b1; busy = 1'b0; end
      PS_DIM:    begin logic_en = 1'b1; link_en = 1'b1; end
      PS_DROP:   logic_en = 1'b1;
      default:   busy = 1'b1;
    endcase
  end
endmodule

// File: rtl/pseq_pix_gate.sv
module pseq_pix_gate #(
  parameter int W = 21
) (
  input  logic         open_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign d_o[b] = d_i[b] & open_i;
  end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pseq_pkg::*;
#(
  parameter int T_LINK = 20,
  parameter int T_LAMP = 1,
  parameter int T_DIM  = 150,
  parameter int T_DROP = 5,
  parameter int T_REST = 200,
  parameter int PIX_W  = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic             panel_req,
  input  logic [PIX_W-1:0] pix_in,
  output logic             logic_en,
  output logic             link_en,
  output logic             lamp_en,
  output logic             seq_busy,
  output logic [PIX_W-1:0] pix_out
);
  localparam int MAXD = dmax(dmax(dmax(T_LINK, T_LAMP), dmax(T_DIM, T_DROP)), T_REST);
  localparam int CW   = $clog2(MAXD + 1) + 1;

  pseq_state_t state;

  pseq_fsm #(
    .T_LINK(T_LINK), .T_LAMP(T_LAMP), .T_DIM(T_DIM),
    .T_DROP(T_DROP), .T_REST(T_REST), .CW(CW)
  ) u_fsm (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_ms),
    .req  (panel_req),
    .state(state)
  );

  pseq_decode u_dec (
    .state   (state),
    .logic_en(logic_en),
    .link_en (link_en),
    .lamp_en (lamp_en),
    .busy    (seq_busy)
  );

  pseq_pix_gate #(.W(PIX_W)) u_gate (
    .open_i(link_en),
    .d_i   (pix_in),
    .d_o   (pix_out)
  );
endmodule

// File: rtl/panel_pwr_seq_chk.sv
module panel_pwr_seq_chk #(
  parameter int T_LINK = 20,
  parameter int T_DIM  = 150,
  parameter int T_REST = 200,
  parameter int PIX_W  = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_ms,
  input logic             logic_en,
  input logic             link_en,
  input logic             lamp_en,
  input logic             seq_busy,
  input logic [PIX_W-1:0] pix_out
);
  localparam int SAT = 1_000_000;
  int up_ticks, off_ticks, dim_ticks;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_ticks <= 0; off_ticks <= 0; dim_ticks <= 0;
    end else begin
      if (!logic_en || link_en)          up_ticks <= 0;
      else if (tick_ms && up_ticks < SAT) up_ticks <= up_ticks + 1;
      if (logic_en)                        off_ticks <= 0;
      else if (tick_ms && off_ticks < SAT) off_ticks <= off_ticks + 1;
      if (!link_en || lamp_en)             dim_ticks <= 0;
      else if (tick_ms && dim_ticks < SAT) dim_ticks <= dim_ticks + 1;
    end
  end

  // R3
  lamp_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_en |-> (link_en && logic_en));
  // R3
  lamp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lamp_en) |-> $past(link_en));
  // R7
  link_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_en |-> logic_en);
  // R6
  pix_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en |-> (pix_out == '0));
  // R2
  link_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_en) |-> (up_ticks >= T_LINK && up_ticks <= T_LINK + 1));
  // R4
  dim_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_en) |-> (dim_ticks >= T_DIM && $past(!lamp_en) && logic_en));
  // R5
  rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(logic_en) |-> (off_ticks >= T_REST));
  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_en |-> !seq_busy);
endmodule

bind panel_pwr_seq panel_pwr_seq_chk #(
  .T_LINK(T_LINK), .T_DIM(T_DIM), .T_REST(T_REST), .PIX_W(PIX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .logic_en(logic_en),
  .link_en(link_en), .lamp_en(lamp_en), .seq_busy(seq_busy), .pix_out(pix_out)
);

// File: tb/sim_panel_pwr_seq.sv
`timescale 1ns/1ps
module sim_panel_pwr_seq;
  localparam int T_LINK = 3, T_LAMP = 2, T_DIM = 4, T_DROP = 2, T_REST = 6, PIX_W = 21;

  logic clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b0, panel_req = 1'b0;
  logic [PIX_W-1:0] pix_in = '0;
  logic logic_en, link_en, lamp_en, seq_busy;
  logic [PIX_W-1:0] pix_out;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  panel_pwr_seq #(.T_LINK(T_LINK), .T_LAMP(T_LAMP), .T_DIM(T_DIM),
                  .T_DROP(T_DROP), .T_REST(T_REST), .PIX_W(PIX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .panel_req(panel_req),
    .pix_in(pix_in), .logic_en(logic_en), .link_en(link_en),
    .lamp_en(lamp_en), .seq_busy(seq_busy), .pix_out(pix_out));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: phase 0 off, 1 supply, 2 link, 3 lit, 4 dim, 5 drop
  int ph = 0, cnt = 0;
  function automatic int lim(input int p);
    case (p)
      0: return T_REST; 1: return T_LINK; 2: return T_LAMP;
      4: return T_DIM;  5: return T_DROP; default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int nx;
    bit ex;
    if (!rst_n) begin ph = 0; cnt = 0; end
    else begin
      ex = (cnt >= lim(ph));
      nx = ph;
      case (ph)
        0: if (panel_req && ex) nx = 1;
        1: if (ex) nx = panel_req ? 2 : 5;
        2: if (ex) nx = panel_req ? 3 : 4;
        3: if (!panel_req) nx = 4;
        4: if (ex) nx = 5;
        5: if (ex) nx = 0;
        default: nx = 0;
      endcase
      if (nx != ph) begin ph = nx; cnt = 0; end
      else if (tick_ms) cnt++;
    end
  end

  // Tick every 4 clocks; per-cycle comparison; pixel pattern
  int tdiv = 0;
  logic [PIX_W-1:0] lfsr = 21'h1ACE5;
  int lamp_off_ticks = 0, supply_ticks = 0;
  logic prev_link = 0, prev_lamp = 0;

  always @(negedge clk) begin
    bit e_logic, e_link, e_lamp, e_busy;
    if (rst_n) begin
      e_logic = (ph >= 1);
      e_link  = (ph >= 2 && ph <= 4);
      e_lamp  = (ph == 3);
      e_busy  = !(ph == 0 || ph == 3);
      chk(logic_en == e_logic, "R2", "logic_en", logic_en, e_logic);
      chk(link_en == e_link, "R2", "link_en", link_en, e_link);
      chk(lamp_en == e_lamp, "R3", "lamp_en", lamp_en, e_lamp);
      chk(seq_busy == e_busy, "R9", "seq_busy", seq_busy, e_busy);
      chk(pix_out == (e_link ? pix_in : '0), "R6", "pix_out", pix_out,
          e_link ? pix_in : '0);
      // R7 supply under link
      if (link_en) chk(logic_en, "R7", "logic_en under link", logic_en, 1);
      // R4 link drop after dim wait
      if (prev_link && !link_en && prev_lamp == 0 && logic_en)
        chk(lamp_off_ticks >= T_DIM, "R4", "dim ticks", lamp_off_ticks, T_DIM);
      if (lamp_en || !link_en) lamp_off_ticks = 0;
      else if (tick_ms) lamp_off_ticks++;
      if (!logic_en) supply_ticks = 0;
      else if (tick_ms) supply_ticks++;
      prev_link = link_en; prev_lamp = lamp_en;
    end else begin
      // R1 reset state
      chk({logic_en, link_en, lamp_en, seq_busy} == 4'b0, "R1", "enables in reset",
          {logic_en, link_en, lamp_en, seq_busy}, 0);
      chk(pix_out == '0, "R1", "pix_out in reset", pix_out, 0);
    end
    tdiv = (tdiv + 1) % 4;
    tick_ms = (tdiv == 0);
    lfsr = {lfsr[PIX_W-2:0], lfsr[PIX_W-1] ^ lfsr[1]};
    pix_in = lfsr;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    // R5: early request after reset is held
    idle(2);
    panel_req = 1'b1;
    idle(6);
    chk(logic_en == 0, "R5", "early request held", logic_en, 0);
    wait (lamp_en); idle(1);
    // R2: lit means full power-up completed
    chk(link_en && logic_en, "R2", "lit with link and supply", {link_en, logic_en}, 3);
    idle(20);
    panel_req = 1'b0;
    idle(1);
    chk(lamp_en == 0 && link_en == 1, "R4", "lamp first off", {lamp_en, link_en}, 1);
    wait (!logic_en); idle(1);
    // R8: abort during supply step
    panel_req = 1'b1;
    wait (logic_en); idle(1);
    panel_req = 1'b0;
    wait (!logic_en); idle(1);
    chk(link_en == 0, "R8", "link stayed off after supply abort", link_en, 0);
    // R8: abort during link step
    panel_req = 1'b1;
    wait (link_en); idle(1);
    panel_req = 1'b0;
    idle(1);
    chk(lamp_en == 0 && link_en == 1, "R8", "dim wait after link abort",
        {lamp_en, link_en}, 1);
    wait (!logic_en); idle(1);
    // R10: request returns during power-down
    panel_req = 1'b1;
    wait (lamp_en); idle(5);
    panel_req = 1'b0;
    idle(3);
    panel_req = 1'b1;
    idle(2);
    chk(lamp_en == 0, "R10", "no relight during down", lamp_en, 0);
    wait (!logic_en); idle(1);
    chk(logic_en == 0, "R10", "supply cut despite request", logic_en, 0);
    wait (lamp_en); idle(8);
    done = 1;
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(0, "WDOG", "watchdog expired", 0, 1);
      finish_up();
    end
  end
endmodule